// File: doc/BRIEF.md
# Indirect-Then-Tally Word Updater

This block carries out the alter step when an indirect word is read, altered and written back. It receives a 36-bit indirect word together with a 4-bit tally designator. It returns the rewritten word, a write-enable for the rewrite, the effective address and character position for the current instruction, a tally-runout indicator update, and a fault flag. The word holds an 18-bit address in its most significant bits (bits 35:18). Below that sits a 12-bit tally (bits 17:6), and the lowest six bits are a tag (bits 5:0). Character modes keep the character position in tag bits 2:0. Delta modes use all six tag bits as an unsigned step. Address arithmetic wraps modulo 2^18 and tally arithmetic wraps modulo 2^12.

Designator codes: 1001 plain indirect, 1000 character indirect, 1110 increment-after, 1111 increment-after (continuing), 1100 decrement-before, 1101 decrement-before (continuing), 1011 add delta, 0100 subtract delta, 1010 sequence character, 0000 fault. The block treats both continuing codes exactly like their plain forms, because chaining is handled outside it.

Both sides use valid/ready handshakes with a single output register. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output payload holds still and no new word is accepted.

Top module: `itt_word_updater`

## Requirements
- R1: Codes 1110 and 1111 give effective address = original address. They write back address+1 and tally-1, with the tag unchanged.
- R2: Codes 1100 and 1101 write back address-1 and tally+1, with the tag unchanged. The effective address is the decremented address.
- R3: Code 1011 writes back address plus the zero-extended 6-bit tag, and tally-1. The tag is unchanged and the effective address is the original address.
- R4: Code 0100 writes back address minus the zero-extended 6-bit tag, and tally+1. The tag is unchanged and the effective address is the updated address.
- R5: Code 1010 reports the original address and the original character position (tag bits 2:0), and writes back tally-1. If the position is below 5 it is incremented. Otherwise it becomes 0 and the address is incremented. Tag bits 5:3 are kept.
- R6: For all rewriting codes, `out_tro_upd`=1 and `out_tro_val`=1 exactly when the written-back tally is zero.
- R7: Codes 1001 and 1000 set `out_wr`=0 and `out_tro_upd`=0, and `out_word` equals the input word. The effective address is the address field. `out_char` is tag bits 2:0 for 1000 and 0 for 1001.
- R8: Code 0000 and every unlisted code raise `out_fault` with `out_wr`=0, `out_tro_upd`=0 and `out_ea`=0, and `out_word` equals the input word.
- R9: A word accepted on one edge gives `out_valid`=1 after that edge. `in_ready` = !`out_valid` || `out_ready`. A stalled output keeps its payload unchanged.
- R10: After reset `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word and designator are valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 36 | Fetched indirect word |
| in_dsg | input | 4 | Tally designator |
| out_valid | output | 1 | Result payload is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 36 | Word to write back |
| out_ea | output | 18 | Effective address for the instruction |
| out_char | output | 3 | Character position for the instruction |
| out_wr | output | 1 | Rewrite required |
| out_tro_upd | output | 1 | Tally-runout indicator is to be updated |
| out_tro_val | output | 1 | New tally-runout value |
| out_fault | output | 1 | Fault-tag fault raised |

## Verification
A misdecoded designator shows in the single result that follows the word. It appears as a wrong write-enable, a wrong choice between the original and the updated address on `out_ea`, or a missing fault. A fault in the wrap arithmetic shows only at the field boundaries: address all-ones, tally one, and character position five. Vectors are therefore placed exactly there. A broken output register shows within one stalled cycle as a changed payload or a dropped second word.

// File: rtl/itt_pkg.sv
package itt_pkg;

  typedef enum logic [2:0] {
    OP_PASS,
    OP_PASSCHAR,
    OP_INCR,
    OP_DECR,
    OP_ADDD,
    OP_SUBD,
    OP_CHSEQ,
    OP_FAULT
  } op_e;

  localparam logic [3:0] DSG_F   = 4'b0000;
  localparam logic [3:0] DSG_SD  = 4'b0100;
  localparam logic [3:0] DSG_CI  = 4'b1000;
  localparam logic [3:0] DSG_I   = 4'b1001;
  localparam logic [3:0] DSG_SC  = 4'b1010;
  localparam logic [3:0] DSG_AD  = 4'b1011;
  localparam logic [3:0] DSG_DI  = 4'b1100;
  localparam logic [3:0] DSG_DIC = 4'b1101;
  localparam logic [3:0] DSG_ID  = 4'b1110;
  localparam logic [3:0] DSG_IDC = 4'b1111;

endpackage

// File: rtl/itt_decode.sv
module itt_decode
  import itt_pkg::*;
(
  input  logic [3:0] dsg,
  output op_e        op
);

  always_comb begin
    case (dsg)
      DSG_I:            op = OP_PASS;
      DSG_CI:           op = OP_PASSCHAR;
      DSG_ID, DSG_IDC:  op = OP_INCR;
      DSG_DI, DSG_DIC:  op = OP_DECR;
      DSG_AD:           op = OP_ADDD;
      DSG_SD:           op = OP_SUBD;
      DSG_SC:           op = OP_CHSEQ;
      default:          op = OP_FAULT;
    endcase
  end

endmodule

// File: rtl/itt_alter.sv
module itt_alter
  import itt_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int TALLY_W = 12,
  parameter int TAG_W   = 6,
  parameter int CHAR_W  = 3,
  parameter int CHARS   = 6,
  localparam int WORD_W = ADDR_W + TALLY_W + TAG_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  op_e               op,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] ea,
  output logic [CHAR_W-1:0] chpos,
  output logic              wr,
  output logic              tro_upd,
  output logic              tro_val,
  output logic              fault
);

  localparam logic [CHAR_W-1:0] LAST_CH = CHAR_W'(CHARS - 1);

  logic [ADDR_W-1:0]  addr, n_addr, delta;
  logic [TALLY_W-1:0] tally, n_tally;
  logic [TAG_W-1:0]   tag, n_tag;
  logic [CHAR_W-1:0]  cur_ch;

  assign addr   = word_i[WORD_W-1 -: ADDR_W];
  assign tally  = word_i[TAG_W +: TALLY_W];
  assign tag    = word_i[TAG_W-1:0];
  assign cur_ch = tag[CHAR_W-1:0];
  assign delta  = ADDR_W'(tag);

  always_comb begin
    n_addr  = addr;
    n_tally = tally;
    n_tag   = tag;
    ea      = addr;
    chpos   = '0;
    wr      = 1'b0;
    tro_upd = 1'b0;
    fault   = 1'b0;
    case (op)
      OP_PASS: ;
      OP_PASSCHAR: chpos = cur_ch;
      OP_INCR: begin
        n_addr  = addr + ADDR_W'(1);
        n_tally = tally - TALLY_W'(1);
        wr = 1'b1; tro_upd = 1'b1;
      end
      OP_DECR: begin
        n_addr  = addr - ADDR_W'(1);
        n_tally = tally + TALLY_W'(1);
        ea = n_addr;
        wr = 1'b1; tro_upd = 1'b1;
      end
      OP_ADDD: begin
        n_addr  = addr + delta;
        n_tally = tally - TALLY_W'(1);
        wr = 1'b1; tro_upd = 1'b1;
      end
      OP_SUBD: begin
        n_addr  = addr - delta;
        n_tally = tally + TALLY_W'(1);
        ea = n_addr;
        wr = 1'b1; tro_upd = 1'b1;
      end
      OP_CHSEQ: begin
        chpos   = cur_ch;
        n_tally = tally - TALLY_W'(1);
        if (cur_ch >= LAST_CH) begin
          n_tag[CHAR_W-1:0] = '0;
          n_addr = addr + ADDR_W'(1);
        end else begin
          n_tag[CHAR_W-1:0] = cur_ch + CHAR_W'(1);
        end
        wr = 1'b1; tro_upd = 1'b1;
      end
      default: begin
        fault = 1'b1;
        ea    = '0;
      end
    endcase
  end

  assign tro_val = tro_upd && (n_tally == '0);
  assign word_o  = {n_addr, n_tally, n_tag};

endmodule

// File: rtl/itt_out_stage.sv
module itt_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

endmodule

// File: rtl/itt_word_updater.sv
module itt_word_updater
  import itt_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int TALLY_W = 12,
  parameter int TAG_W   = 6,
  parameter int CHAR_W  = 3,
  parameter int CHARS   = 6,
  localparam int WORD_W = ADDR_W + TALLY_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [3:0]        in_dsg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [ADDR_W-1:0] out_ea,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_wr,
  output logic              out_tro_upd,
  output logic              out_tro_val,
  output logic              out_fault
);

  localparam int PW = WORD_W + ADDR_W + CHAR_W + 4;

  op_e               op;
  logic [WORD_W-1:0] nx_word;
  logic [ADDR_W-1:0] nx_ea;
  logic [CHAR_W-1:0] nx_ch;
  logic              nx_wr, nx_tu, nx_tv, nx_flt;
  logic [PW-1:0]     pay_in, pay_out;

  itt_decode u_dec (
    .dsg (in_dsg),
    .op  (op)
  );

  itt_alter #(
    .ADDR_W (ADDR_W), .TALLY_W (TALLY_W), .TAG_W (TAG_W),
    .CHAR_W (CHAR_W), .CHARS (CHARS)
  ) u_alt (
    .word_i  (in_word),
    .op      (op),
    .word_o  (nx_word),
    .ea      (nx_ea),
    .chpos   (nx_ch),
    .wr      (nx_wr),
    .tro_upd (nx_tu),
    .tro_val (nx_tv),
    .fault   (nx_flt)
  );

  assign pay_in = {nx_word, nx_ea, nx_ch, nx_wr, nx_tu, nx_tv, nx_flt};

  itt_out_stage #(.PW (PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_word, out_ea, out_char, out_wr, out_tro_upd, out_tro_val, out_fault} = pay_out;

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> !out_wr && !out_tro_upd && (out_ea == '0)); // R8

  AST_RUNOUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tro_upd |-> out_tro_val == (out_word[TAG_W +: TALLY_W] == '0)); // R6

  AST_NOWRITE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wr |-> !out_tro_upd && !out_tro_val); // R7

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ea)
                                && $stable(out_char) && $stable(out_wr)); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

endmodule

// File: tb/sim_itt_word_updater.sv
module sim_itt_word_updater;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_word = '0;
  logic [3:0]  in_dsg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_word;
  logic [17:0] out_ea;
  logic [2:0]  out_char;
  logic        out_wr, out_tro_upd, out_tro_val, out_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  itt_word_updater u0 (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_word (in_word), .in_dsg (in_dsg),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_word (out_word), .out_ea (out_ea), .out_char (out_char),
    .out_wr (out_wr), .out_tro_upd (out_tro_upd), .out_tro_val (out_tro_val),
    .out_fault (out_fault)
  );

  // {dsg, word_in, word_exp, ea, char, wr, tro_upd, tro_val, fault}
  localparam int NV = 16;
  localparam logic [100:0] VT [NV] = '{
    {4'hE, 18'h00100, 12'h005, 6'h00, 18'h00101, 12'h004, 6'h00, 18'h00100, 3'd0, 4'b1100}, // R1
    {4'hE, 18'h3FFFF, 12'h001, 6'h00, 18'h00000, 12'h000, 6'h00, 18'h3FFFF, 3'd0, 4'b1110}, // R1 R6
    {4'hF, 18'h12345, 12'h002, 6'h2A, 18'h12346, 12'h001, 6'h2A, 18'h12345, 3'd0, 4'b1100}, // R1
    {4'hC, 18'h00200, 12'hFFF, 6'h00, 18'h001FF, 12'h000, 6'h00, 18'h001FF, 3'd0, 4'b1110}, // R2 R6
    {4'hD, 18'h00000, 12'h010, 6'h00, 18'h3FFFF, 12'h011, 6'h00, 18'h3FFFF, 3'd0, 4'b1100}, // R2
    {4'hB, 18'h01000, 12'h003, 6'h05, 18'h01005, 12'h002, 6'h05, 18'h01000, 3'd0, 4'b1100}, // R3
    {4'hB, 18'h3FFF0, 12'h001, 6'h3F, 18'h0002F, 12'h000, 6'h3F, 18'h3FFF0, 3'd0, 4'b1110}, // R3 R6
    {4'h4, 18'h01000, 12'h003, 6'h05, 18'h00FFB, 12'h004, 6'h05, 18'h00FFB, 3'd0, 4'b1100}, // R4
    {4'h4, 18'h00002, 12'hFFF, 6'h3F, 18'h3FFC3, 12'h000, 6'h3F, 18'h3FFC3, 3'd0, 4'b1110}, // R4 R6
    {4'hA, 18'h00400, 12'h007, 6'h02, 18'h00400, 12'h006, 6'h03, 18'h00400, 3'd2, 4'b1100}, // R5
    {4'hA, 18'h00400, 12'h001, 6'h3D, 18'h00401, 12'h000, 6'h38, 18'h00400, 3'd5, 4'b1110}, // R5 R6
    {4'hA, 18'h00010, 12'h005, 6'h07, 18'h00011, 12'h004, 6'h00, 18'h00010, 3'd7, 4'b1100}, // R5
    {4'h9, 18'h0ABCD, 12'h123, 6'h11, 18'h0ABCD, 12'h123, 6'h11, 18'h0ABCD, 3'd0, 4'b0000}, // R7
    {4'h8, 18'h0ABCD, 12'h123, 6'h14, 18'h0ABCD, 12'h123, 6'h14, 18'h0ABCD, 3'd4, 4'b0000}, // R7
    {4'h0, 18'h0ABCD, 12'h123, 6'h14, 18'h0ABCD, 12'h123, 6'h14, 18'h00000, 3'd0, 4'b0001}, // R8
    {4'h3, 18'h11111, 12'h222, 6'h33, 18'h11111, 12'h222, 6'h33, 18'h00000, 3'd0, 4'b0001}  // R8
  };

  function automatic string req_of(input logic [3:0] d);
    case (d)
      4'hE, 4'hF: return "R1";
      4'hC, 4'hD: return "R2";
      4'hB:       return "R3";
      4'h4:       return "R4";
      4'hA:       return "R5";
      4'h9, 4'h8: return "R7";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic [60:0] got();
    return {out_word, out_ea, out_char, out_wr, out_tro_upd, out_tro_val, out_fault};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] d, input logic [35:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_dsg = d; in_word = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VT[i][100:97], VT[i][96:61]);
      chk("R9 valid", 64'(out_valid), 64'd1);
      chk(req_of(VT[i][100:97]), 64'(got()), 64'(VT[i][60:0]));
      if (VT[i][2]) chk("R6 runout", 64'(out_tro_val), 64'(VT[i][1]));
    end

    // R9: stall holds payload and blocks the next word
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_dsg = 4'hE; in_word = {18'h00050, 12'h009, 6'h00};
    @(posedge clk);
    @(negedge clk);
    chk("R9 stall valid", 64'(out_valid), 64'd1);
    chk("R9 stall ready", 64'(in_ready), 64'd0);
    in_dsg = 4'hC; in_word = {18'h00070, 12'h000, 6'h00};
    @(posedge clk);
    @(negedge clk);
    chk("R9 hold", 64'(out_word), 64'({18'h00051, 12'h008, 6'h00}));
    chk("R9 hold ea", 64'(out_ea), 64'h00050);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 after stall", 64'(out_word), 64'({18'h0006F, 12'h001, 6'h00}));
    chk("R2 after stall ea", 64'(out_ea), 64'h0006F);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);

    // R10: reset mid-stream empties the output
    out_ready = 1'b0;
    send(4'hE, 36'h0);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 rereset valid", 64'(out_valid), 64'd0);
    chk("R10 rereset ready", 64'(in_ready), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule